// File: doc/BRIEF.md
# SHA-256 Block Compression Engine

This engine compresses one already-padded 512-bit message block per command. It keeps the 256-bit chaining value between commands, so a long message is hashed by issuing a start command for its first block and a continue command for each later block. Padding, length encoding and any bus access are handled outside the engine.

Each command is a one-cycle pulse taken only while the ready flag is high. The engine then executes the 64 rounds at one round per clock. It expands the message schedule as it goes in a sliding window of sixteen 32-bit words. One further cycle adds the working registers into the chaining value. Ready then returns high and the digest is flagged valid.

Top module: `sha2_compress`

## Requirements
- R1: After a synchronous reset, `rdy` is 1, `dgst_vld` is 0 and `digest` is all zeros.
- R2: A `start` pulse accepted while `rdy` is 1 reloads the chaining value with the standard SHA-256 initial hash and compresses `blk`. The single padded block for "abc" gives BA7816BF8F01CFEA414140DE5DAE2223B00361A396177A9CB410FF61F20015AD.
- R3: A `cont` pulse accepted while `rdy` is 1 compresses `blk` starting from the present chaining value. For the 448-bit two-block vector, block one gives 85E655D6417A17953363376A624CDE5C76E09589CAC5F811CC4B32C1F20E533A and block two then gives 248D6A61D20638B8E5C026930C3E6039A33CE45964FF2167F6ECEDD419DB06C1.
- R4: `rdy` is 0 from the clock edge that accepts a command until it returns to 1 exactly 65 clock edges later (64 rounds plus one fold cycle).
- R5: `dgst_vld` clears on the edge that accepts a command and sets together with `rdy`. It then stays set, with `digest` unchanged, until the next accepted command.
- R6: While `rdy` is 0, `start`, `cont` and changes of `blk` have no effect. `blk` is sampled only on the accepting edge, and the result and latency are unchanged.
- R7: If `start` and `cont` are both high on an accepting edge, `start` wins and the chaining value restarts from the initial hash.
- R8: Block word 0 is `blk[511:480]` and is used in round 0. Word 15 is `blk[31:0]`. The digest carries H0 in bits 255:224 down to H7 in bits 31:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse: begin a new message with this block |
| cont | input | 1 | One-cycle pulse: compress this block and chain |
| blk | input | 512 | Padded message block, word 0 in the top bits |
| rdy | output | 1 | High when a command can be accepted |
| digest | output | 256 | Chaining value, H0 in the top bits |
| dgst_vld | output | 1 | Digest holds a finished result |

## Verification
Two events can fall in the same cycle. The first is that both command inputs are asserted on one accepting edge. The bench provokes this after a first block has left a non-initial chaining value, then checks that the digest equals the single-block "abc" result, which only a restart from the initial hash can produce. The second is that a command arrives while a block is still being compressed. The bench injects both pulses, together with a different block, part-way through a run. It then checks that the first-block result and the 65-cycle latency are unchanged, and that a following continue still yields the correct two-block digest.

// File: rtl/sha2_pkg.sv
package sha2_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // index 7 = H0 ... index 0 = H7, so the packed vector is the digest layout
  localparam logic [7:0][WORD_W-1:0] IV = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_s0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_s1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t sml_s0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sml_s1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t choose(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t major(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction
endpackage

// File: rtl/sha2_kconst.sv
module sha2_kconst #(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0]     idx,
  output sha2_pkg::word_t      k
);
  always_comb begin
    case (idx)
      6'd0:  k = 32'h428a2f98; 6'd1:  k = 32'h71374491; 6'd2:  k = 32'hb5c0fbcf; 6'd3:  k = 32'he9b5dba5;
      6'd4:  k = 32'h3956c25b; 6'd5:  k = 32'h59f111f1; 6'd6:  k = 32'h923f82a4; 6'd7:  k = 32'hab1c5ed5;
      6'd8:  k = 32'hd807aa98; 6'd9:  k = 32'h12835b01; 6'd10: k = 32'h243185be; 6'd11: k = 32'h550c7dc3;
      6'd12: k = 32'h72be5d74; 6'd13: k = 32'h80deb1fe; 6'd14: k = 32'h9bdc06a7; 6'd15: k = 32'hc19bf174;
      6'd16: k = 32'he49b69c1; 6'd17: k = 32'hefbe4786; 6'd18: k = 32'h0fc19dc6; 6'd19: k = 32'h240ca1cc;
      6'd20: k = 32'h2de92c6f; 6'd21: k = 32'h4a7484aa; 6'd22: k = 32'h5cb0a9dc; 6'd23: k = 32'h76f988da;
      6'd24: k = 32'h983e5152; 6'd25: k = 32'ha831c66d; 6'd26: k = 32'hb00327c8; 6'd27: k = 32'hbf597fc7;
      6'd28: k = 32'hc6e00bf3; 6'd29: k = 32'hd5a79147; 6'd30: k = 32'h06ca6351; 6'd31: k = 32'h14292967;
      6'd32: k = 32'h27b70a85; 6'd33: k = 32'h2e1b2138; 6'd34: k = 32'h4d2c6dfc; 6'd35: k = 32'h53380d13;
      6'd36: k = 32'h650a7354; 6'd37: k = 32'h766a0abb; 6'd38: k = 32'h81c2c92e; 6'd39: k = 32'h92722c85;
      6'd40: k = 32'ha2bfe8a1; 6'd41: k = 32'ha81a664b; 6'd42: k = 32'hc24b8b70; 6'd43: k = 32'hc76c51a3;
      6'd44: k = 32'hd192e819; 6'd45: k = 32'hd6990624; 6'd46: k = 32'hf40e3585; 6'd47: k = 32'h106aa070;
      6'd48: k = 32'h19a4c116; 6'd49: k = 32'h1e376c08; 6'd50: k = 32'h2748774c; 6'd51: k = 32'h34b0bcb5;
      6'd52: k = 32'h391c0cb3; 6'd53: k = 32'h4ed8aa4a; 6'd54: k = 32'h5b9cca4f; 6'd55: k = 32'h682e6ff3;
      6'd56: k = 32'h748f82ee; 6'd57: k = 32'h78a5636f; 6'd58: k = 32'h84c87814; 6'd59: k = 32'h8cc70208;
      6'd60: k = 32'h90befffa; 6'd61: k = 32'ha4506ceb; 6'd62: k = 32'hbef9a3f7; default: k = 32'hc67178f2;
    endcase
  end
endmodule

// File: rtl/sha2_sched.sv
module sha2_sched #(
  parameter int BLK_W = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic [BLK_W-1:0] blk,
  output sha2_pkg::word_t  w_cur
);
  import sha2_pkg::*;
  localparam int NW = BLK_W / WORD_W;

  logic [NW-1:0][WORD_W-1:0] win;
  word_t w_new;

  // window[0] is W[t]; the appended word is W[t+16]
  assign w_new = sml_s1(win[NW-2]) + win[NW-7] + sml_s0(win[1]) + win[0];
  assign w_cur = win[0];

  for (genvar i = 0; i < NW; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        win[i] <= '0;
      end else if (load) begin
        win[i] <= blk[BLK_W-1-WORD_W*i -: WORD_W];
      end else if (shift) begin
        if (i == NW-1) win[i] <= w_new;
        else           win[i] <= win[(i+1) % NW];
      end
    end
  end
endmodule

// File: rtl/sha2_round.sv
module sha2_round (
  input  logic [7:0][31:0] st_in,
  input  sha2_pkg::word_t  k,
  input  sha2_pkg::word_t  w,
  output logic [7:0][31:0] st_out
);
  import sha2_pkg::*;
  // index 7 = a ... index 0 = h
  word_t a, b, c, d, e, f, g, h, t1, t2;
  always_comb begin
    {a, b, c, d, e, f, g, h} = st_in;
    t1 = h + big_s1(e) + choose(e, f, g) + k + w;
    t2 = big_s0(a) + major(a, b, c);
    st_out = {t1 + t2, a, b, c, d + t1, e, f, g};
  end
endmodule

// File: rtl/sha2_compress.sv
module sha2_compress #(
  parameter int BLK_W  = 512,
  parameter int DIG_W  = 256,
  parameter int ROUNDS = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cont,
  input  logic [BLK_W-1:0] blk,
  output logic             rdy,
  output logic [DIG_W-1:0] digest,
  output logic             dgst_vld
);
  import sha2_pkg::*;
  localparam int CW = $clog2(ROUNDS);
  localparam int NH = DIG_W / WORD_W;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FOLD} st_e;
  st_e st;

  logic [NH-1:0][WORD_W-1:0] hreg, work, work_nxt;
  logic [CW-1:0] rc;
  word_t k_cur, w_cur;
  logic go;

  assign go = (st == S_IDLE) && (start || cont);

  sha2_kconst #(.IDX_W(CW)) u_k (.idx(rc), .k(k_cur));

  sha2_sched #(.BLK_W(BLK_W)) u_sched (
    .clk(clk), .rst(rst), .load(go), .shift(st == S_RUN),
    .blk(blk), .w_cur(w_cur));

  sha2_round u_round (.st_in(work), .k(k_cur), .w(w_cur), .st_out(work_nxt));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      rdy      <= 1'b1;
      dgst_vld <= 1'b0;
      hreg     <= '0;
      work     <= '0;
      rc       <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          st       <= S_RUN;
          rdy      <= 1'b0;
          dgst_vld <= 1'b0;
          rc       <= '0;
          if (start) begin
            hreg <= IV;
            work <= IV;
          end else begin
            work <= hreg;
          end
        end
        S_RUN: begin
          work <= work_nxt;
          rc   <= rc + 1'b1;
          if (rc == CW'(ROUNDS-1)) st <= S_FOLD;
        end
        default: begin
          for (int i = 0; i < NH; i++) hreg[i] <= hreg[i] + work[i];
          rdy      <= 1'b1;
          dgst_vld <= 1'b1;
          st       <= S_IDLE;
        end
      endcase
    end
  end

  assign digest = hreg;
endmodule

// File: rtl/sha2_compress_chk.sv
module sha2_compress_chk #(
  parameter int DIG_W  = 256,
  parameter int ROUNDS = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             cont,
  input logic             rdy,
  input logic [DIG_W-1:0] digest,
  input logic             dgst_vld
);
  logic [15:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst || rdy) busy_cnt <= '0;
    else            busy_cnt <= busy_cnt + 1'b1;
  end

  // R4
  accept_drops_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy && (start || cont)) |=> (!rdy && !dgst_vld));
  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy) |-> (busy_cnt == 16'(ROUNDS + 1)));
  // R5
  vld_needs_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    dgst_vld |-> rdy);
  // R5
  vld_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dgst_vld && !start && !cont) |=> (dgst_vld && $stable(digest)));
  // R6
  busy_digest_chk: assert property (@(posedge clk) disable iff (rst)
    !rdy |=> ($stable(digest) || rdy));
endmodule

bind sha2_compress sha2_compress_chk #(.DIG_W(DIG_W), .ROUNDS(ROUNDS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .cont(cont),
  .rdy(rdy), .digest(digest), .dgst_vld(dgst_vld));

// File: tb/sha2_compress_bench.sv
module sha2_compress_bench;
  localparam logic [511:0] BLK_ABC =
    512'h61626380000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000018;
  localparam logic [255:0] DG_ABC =
    256'hBA7816BF8F01CFEA414140DE5DAE2223B00361A396177A9CB410FF61F20015AD;
  localparam logic [511:0] BLK_M1 =
    512'h6162636462636465636465666465666765666768666768696768696A68696A6B696A6B6C6A6B6C6D6B6C6D6E6C6D6E6F6D6E6F706E6F70718000000000000000;
  localparam logic [255:0] DG_M1 =
    256'h85E655D6417A17953363376A624CDE5C76E09589CAC5F811CC4B32C1F20E533A;
  localparam logic [511:0] BLK_M2 =
    512'h000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000001C0;
  localparam logic [255:0] DG_M2 =
    256'h248D6A61D20638B8E5C026930C3E6039A33CE45964FF2167F6ECEDD419DB06C1;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, cont = 1'b0;
  logic [511:0] blk = '0;
  logic rdy, dgst_vld;
  logic [255:0] digest;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  sha2_compress u_sha2_compress (
    .clk(clk), .rst(rst), .start(start), .cont(cont), .blk(blk),
    .rdy(rdy), .digest(digest), .dgst_vld(dgst_vld));

  task automatic check(input logic ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // issue a command, optionally inject a busy-time command at cycle inj
  task automatic run(input logic s, input logic c, input logic [511:0] b,
                     input int inj, output int lat);
    @(negedge clk);
    start = s; cont = c; blk = b;
    @(negedge clk);
    start = 0; cont = 0; blk = '0;
    check(rdy == 1'b0, "R4 rdy low after accept", 256'(rdy), 256'd0);
    check(dgst_vld == 1'b0, "R5 vld cleared by accept", 256'(dgst_vld), 256'd0);
    lat = 0;
    while (!rdy && lat < 200) begin
      if (inj != 0 && lat == inj) begin
        start = 1; cont = 1; blk = BLK_ABC;
      end
      @(negedge clk);
      start = 0; cont = 0;
      lat++;
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 0;
    check(rdy == 1'b1, "R1 rdy", 256'(rdy), 256'd1);
    check(dgst_vld == 1'b0, "R1 vld", 256'(dgst_vld), 256'd0);
    check(digest == '0, "R1 digest", digest, 256'd0);
  endtask

  task automatic t_abc;
    int lat;
    run(1, 0, BLK_ABC, 0, lat);
    check(digest == DG_ABC, "R2 R8 abc digest", digest, DG_ABC);
    check(lat == 65, "R4 latency", 256'(lat), 256'd65);
    check(dgst_vld == 1'b1, "R5 vld with rdy", 256'(dgst_vld), 256'd1);
  endtask

  task automatic t_chain;
    int lat;
    run(1, 0, BLK_M1, 0, lat);
    check(digest == DG_M1, "R2 first block", digest, DG_M1);
    run(0, 1, BLK_M2, 0, lat);
    check(digest == DG_M2, "R3 chained block", digest, DG_M2);
    check(lat == 65, "R4 latency cont", 256'(lat), 256'd65);
  endtask

  task automatic t_hold;
    repeat (7) @(negedge clk);
    check(dgst_vld == 1'b1, "R5 vld held", 256'(dgst_vld), 256'd1);
    check(digest == DG_M2, "R5 digest held", digest, DG_M2);
  endtask

  task automatic t_ignore;
    int lat;
    run(1, 0, BLK_M1, 20, lat);
    check(digest == DG_M1, "R6 busy command ignored", digest, DG_M1);
    check(lat == 65, "R6 latency unchanged", 256'(lat), 256'd65);
    run(0, 1, BLK_M2, 50, lat);
    check(digest == DG_M2, "R6 chain after ignore", digest, DG_M2);
  endtask

  task automatic t_both;
    int lat;
    run(1, 1, BLK_ABC, 0, lat);
    check(digest == DG_ABC, "R7 start wins", digest, DG_ABC);
    check(dgst_vld == 1'b1, "R7 vld", 256'(dgst_vld), 256'd1);
  endtask

  initial begin
    t_reset();
    t_abc();
    t_chain();
    t_hold();
    t_ignore();
    t_both();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule